// File: doc/BRIEF.md
# Pause Quanta Inhibit Timer

This block holds off a MAC transmitter after a pause request has been received. When the receive side has decoded a pause value, it presents that 16-bit unsigned value with a one-cycle load strobe. The timer keeps the value as a remaining count of pause quanta and drives a transmit-inhibit output while that count is nonzero.

One pause quantum is 512 bit times. The transmit clock domain supplies a strobe that is high for one cycle per bit time. An internal 9-bit prescaler counts these strobes and takes one off the remaining count every 512 of them. The count can therefore be anything from 0 to 65535 quanta.

A new load always takes the place of whatever is running, in whatever state the timer is. It also restarts the prescaler, so the first quantum after a load is always a full 512 bit times. Loading zero ends a pause that is in progress. Frame parsing and the transmit datapath are not part of this block.

Top module: `pq_inhibit_timer`

## Requirements
- R1: After reset, `remaining_o` is 0 and `inhibit_o` is low.
- R2: A cycle with `load_i` high sets `remaining_o` to `pause_val_i` on the next cycle, whatever the earlier count was.
- R3: While counting, `remaining_o` goes down by one in the cycle after each 512th `bit_tick_i` since the last load or the last decrement, and does not change in between.
- R4: Cycles with `bit_tick_i` low do not move the count toward a decrement.
- R5: A load restarts the quantum, so the first decrement after a reload comes only after 512 further ticks, however many ticks the earlier count had taken.
- R6: Loading 0 makes `inhibit_o` low and `remaining_o` 0 on the next cycle, even if a pause was running.
- R7: `inhibit_o` is high exactly when `remaining_o` is nonzero.
- R8: While `remaining_o` is 0, ticks have no effect: the count stays 0, and a later load of 1 still needs a full 512 ticks to expire.
- R9: A load in the same cycle as a tick, including the tick that would end a quantum, takes priority: the loaded value appears unchanged and the prescaler restarts.
- R10: The largest value, 65535, loads unchanged and counts down like any other value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | One-cycle strobe to take in a new pause value |
| pause_val_i | input | 16 | Pause value in quanta, read when `load_i` is high |
| bit_tick_i | input | 1 | High for one cycle per bit time |
| inhibit_o | output | 1 | High while transmission must be held off |
| remaining_o | output | 16 | Number of quanta left |

## Verification
The bench first drives a tick in every cycle. In that pattern it checks the exact cycle in which each decrement happens, so an off-by-one in the quantum length shows up. It then spreads the ticks out with long idle gaps, which separates a prescaler that counts ticks from one that counts cycles. Reloads in the middle of a quantum, zero loads, and ticks while the count is zero show whether the prescaler is restarted and gated correctly. A load in the same cycle as the quantum-ending tick, and a load of 65535, cover priority and the full width of the count.

// File: rtl/pq_pkg.sv
package pq_pkg;
  localparam int unsigned CNT_W       = 16;
  localparam int unsigned QUANTUM_LOG2 = 9;

  // Last prescaler value of a quantum for a given prescaler width.
  function automatic logic [QUANTUM_LOG2-1:0] quantum_last();
    return {QUANTUM_LOG2{1'b1}};
  endfunction

  // Remaining count after one quantum; never goes below zero.
  function automatic logic [CNT_W-1:0] dec_floor(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction
endpackage

// File: rtl/pq_prescaler.sv
module pq_prescaler #(
  parameter int unsigned PW = pq_pkg::QUANTUM_LOG2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic enable_i,
  input  logic tick_i,
  output logic quantum_end_o
);
  localparam logic [PW-1:0] LAST = {PW{1'b1}};

  logic [PW-1:0] phase_q;
  logic          advance;

  assign advance       = enable_i && tick_i && !restart_i;
  assign quantum_end_o = advance && (phase_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || restart_i || !enable_i) begin
      phase_q <= '0;
    end else if (advance) begin
      phase_q <= phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/pq_quanta_counter.sv
module pq_quanta_counter #(
  parameter int unsigned CW = pq_pkg::CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] value_i,
  input  logic          step_i,
  output logic [CW-1:0] count_o,
  output logic          nonzero_o
);
  logic [CW-1:0] count_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (load_i) begin
      count_q <= value_i;
    end else if (step_i) begin
      count_q <= (count_q == '0) ? '0 : count_q - 1'b1;
    end
  end

  assign count_o   = count_q;
  assign nonzero_o = |count_q;
endmodule

// File: rtl/pq_inhibit_timer.sv
module pq_inhibit_timer #(
  parameter int unsigned CNT_W        = pq_pkg::CNT_W,
  parameter int unsigned QUANTUM_LOG2 = pq_pkg::QUANTUM_LOG2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] pause_val_i,
  input  logic             bit_tick_i,
  output logic             inhibit_o,
  output logic [CNT_W-1:0] remaining_o
);
  // Internal events, named so that the checker can see them.
  logic quantum_end;
  logic counting;

  pq_prescaler #(.PW(QUANTUM_LOG2)) u_pre (
    .clk           (clk),
    .rst_n         (rst_n),
    .restart_i     (load_i),
    .enable_i      (counting),
    .tick_i        (bit_tick_i),
    .quantum_end_o (quantum_end)
  );

  pq_quanta_counter #(.CW(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load_i),
    .value_i   (pause_val_i),
    .step_i    (quantum_end),
    .count_o   (remaining_o),
    .nonzero_o (counting)
  );

  assign inhibit_o = counting;
endmodule

// File: rtl/pq_inhibit_timer_chk.sv
module pq_inhibit_timer_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_i,
  input logic [CNT_W-1:0] pause_val_i,
  input logic             bit_tick_i,
  input logic             inhibit_o,
  input logic [CNT_W-1:0] remaining_o,
  input logic             quantum_end
);
  // R2
  load_takes_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> remaining_o == $past(pause_val_i));
  // R3
  quantum_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quantum_end && !load_i) |=> remaining_o == $past(remaining_o) - 1'b1);
  // R3
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!quantum_end && !load_i) |=> $stable(remaining_o));
  // R4
  tick_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick_i |-> !quantum_end);
  // R6
  zero_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && pause_val_i == '0) |=> !inhibit_o);
  // R8
  idle_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (remaining_o == '0) |-> !quantum_end);
  // R9
  load_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !quantum_end);
endmodule

bind pq_inhibit_timer pq_inhibit_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .load_i      (load_i),
  .pause_val_i (pause_val_i),
  .bit_tick_i  (bit_tick_i),
  .inhibit_o   (inhibit_o),
  .remaining_o (remaining_o),
  .quantum_end (quantum_end)
);

// File: tb/tb_pq_inhibit_timer.sv
`timescale 1ns/1ps
module tb_pq_inhibit_timer;
  localparam int QUANTUM = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_i = 1'b0;
  logic [15:0] pause_val_i = '0;
  logic        bit_tick_i = 1'b0;
  logic        inhibit_o;
  logic [15:0] remaining_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pq_inhibit_timer dut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .pause_val_i(pause_val_i),
    .bit_tick_i(bit_tick_i), .inhibit_o(inhibit_o), .remaining_o(remaining_o)
  );

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected inhibit is derived from the count, per R7.
  task automatic check_state(string req, int exp_rem);
    check(req, remaining_o, exp_rem);
    check("R7", inhibit_o, (exp_rem != 0) ? 1 : 0);
  endtask

  task automatic cyc(bit ld, int val, bit tk);
    load_i = ld; pause_val_i = val[15:0]; bit_tick_i = tk;
    @(posedge clk); #1;
    load_i = 1'b0; bit_tick_i = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 0, 1'b1);
  endtask

  task automatic idles(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 0, 1'b0);
  endtask

  task automatic t_reset();
    check_state("R1", 0);
  endtask

  task automatic t_basic();
    cyc(1'b1, 3, 1'b0);
    check_state("R2", 3);
    ticks(QUANTUM - 1);
    check_state("R3", 3);
    ticks(1);
    check_state("R3", 2);
    ticks(2 * QUANTUM - 1);
    check_state("R3", 1);
    ticks(1);
    check_state("R3", 0);
  endtask

  task automatic t_gaps();
    cyc(1'b1, 1, 1'b0);
    for (int i = 0; i < QUANTUM - 1; i++) begin
      cyc(1'b0, 0, 1'b1);
      idles(3);
    end
    check_state("R4", 1);
    idles(1000);
    check_state("R4", 1);
    ticks(1);
    check_state("R4", 0);
  endtask

  task automatic t_reload();
    cyc(1'b1, 5, 1'b0);
    ticks(300);
    cyc(1'b1, 2, 1'b0);
    check_state("R2", 2);
    ticks(300);
    check_state("R5", 2);
    ticks(QUANTUM - 301);
    check_state("R5", 2);
    ticks(1);
    check_state("R5", 1);
    cyc(1'b1, 0, 1'b0);
  endtask

  task automatic t_cancel();
    cyc(1'b1, 4, 1'b0);
    ticks(100);
    check_state("R6", 4);
    cyc(1'b1, 0, 1'b0);
    check_state("R6", 0);
    ticks(QUANTUM + 10);
    check_state("R6", 0);
  endtask

  task automatic t_idle();
    ticks(2000);
    check_state("R8", 0);
    cyc(1'b1, 1, 1'b0);
    ticks(QUANTUM - 1);
    check_state("R8", 1);
    ticks(1);
    check_state("R8", 0);
  endtask

  task automatic t_priority();
    cyc(1'b1, 2, 1'b0);
    ticks(QUANTUM - 1);
    cyc(1'b1, 7, 1'b1);
    check_state("R9", 7);
    ticks(QUANTUM - 1);
    check_state("R9", 7);
    ticks(1);
    check_state("R9", 6);
    cyc(1'b1, 0, 1'b0);
  endtask

  task automatic t_max();
    cyc(1'b1, 65535, 1'b0);
    check_state("R10", 65535);
    ticks(QUANTUM);
    check_state("R10", 65534);
    cyc(1'b1, 0, 1'b0);
    check_state("R10", 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idles(1);
    t_reset();
    t_basic();
    t_gaps();
    t_reload();
    t_cancel();
    t_idle();
    t_priority();
    t_max();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule